// File: doc/BRIEF.md
# Configuration-Dependent Array Address Generator

This block turns a control unit's global address into the bank, row and column seen by a memory that is spread over several processing-element arrays. The global address has 20 bits and a fixed layout: bits [5:0] pick one of 64 element columns, bits [7:6] name one of four arrays, and bits [19:8] carry the row. Each request says whether it is an instruction fetch or a data access. That choice selects which of two 4-bit array masks applies, one mask for instruction fetches and one for data. A mask bit is set for each array that belongs to the current joined configuration. The array number may only select a bank whose mask bit is set. Each element memory holds 2,048 words, so a row must fit in 11 bits.

In the same cycle, the block forms one local operand address for every processing element. Each local address is the sum of a fixed instruction field, an index from a control-unit accumulator, and that element's own index. The sum wraps at 2,048, and a per-element flag reports when it wrapped. All outputs are registered and appear one cycle after the request.

Top module: `arr_addr_gen`

## Requirements
- R1: While reset is high and in the cycle after it falls, out_valid, bank_sel, row_addr, col_sel, addr_fault, pe_addr and pe_ovf are all zero.
- R2: out_valid is high in exactly the cycle after a cycle with req_valid high. All other outputs for that request are updated at the same edge.
- R3: When req_is_data is 1 the request is checked against data_mask. When it is 0 the request is checked against inst_mask.
- R4: For a request without a fault, bank_sel is one-hot, with bit glob_addr[7:6] set.
- R5: addr_fault is 1 when the selected mask has a 0 at bit glob_addr[7:6], or when glob_addr[19] is 1 (row 2,048 or above). When addr_fault is 1, bank_sel and row_addr are zero.
- R6: For a request without a fault, row_addr equals glob_addr[18:8]. For every request, col_sel equals glob_addr[5:0].
- R7: For element i, pe_addr[11i+10:11i] equals (fixed_off + cu_index + pe_index[11i+10:11i]) mod 2048.
- R8: pe_ovf[i] is 1 exactly when the unwrapped three-term sum for element i is 2,048 or more.
- R9: In a cycle with req_valid low, no output other than out_valid changes at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_is_data | input | 1 | 1 = data access, 0 = instruction fetch |
| glob_addr | input | 20 | Global address: row, array number, column |
| inst_mask | input | 4 | Arrays joined for instruction fetches |
| data_mask | input | 4 | Arrays joined for data accesses |
| fixed_off | input | 11 | Fixed offset taken from the instruction |
| cu_index | input | 11 | Index from a control-unit accumulator |
| pe_index | input | 704 | 64 packed 11-bit per-element indices |
| out_valid | output | 1 | Registered results are fresh |
| bank_sel | output | 4 | One-hot target array bank |
| row_addr | output | 11 | Row sent to the element memories |
| col_sel | output | 6 | Element column |
| addr_fault | output | 1 | Array not joined, or row out of range |
| pe_addr | output | 704 | 64 packed 11-bit local addresses |
| pe_ovf | output | 64 | Per-element wrap flags |

## Verification
The assertions assume that the two masks and the request inputs are stable and known at every rising edge once reset is released. They also assume that reset is held for at least one edge. The bench meets these conditions by changing every input only on falling edges. It holds reset for several cycles with req_valid low. Random masks are drawn from the full 4-bit range, including zero, and most random rows are drawn below 2,048, so that requests with and without a fault both occur often.

// File: rtl/arr_addr_pkg.sv
package arr_addr_pkg;
    parameter int GA_W  = 20;
    parameter int COL_W = 6;
    parameter int ARR_W = 2;
    parameter int LOC_W = 11;

    localparam int NUM_ARR = 1 << ARR_W;
    localparam int ROW_LO  = COL_W + ARR_W;
    localparam int ROW_W   = GA_W - ROW_LO;
    localparam int SUM_W   = LOC_W + 2;

    typedef struct packed {
        logic [ROW_W-1:0] row;
        logic [ARR_W-1:0] arr;
        logic [COL_W-1:0] col;
    } gaddr_t;

    typedef enum logic {
        ACC_INST = 1'b0,
        ACC_DATA = 1'b1
    } acc_kind_e;

    typedef struct packed {
        logic [NUM_ARR-1:0] bank;
        logic [LOC_W-1:0]   row;
        logic [COL_W-1:0]   col;
        logic               fault;
    } bank_res_t;

    function automatic logic [NUM_ARR-1:0] arr_onehot(input logic [ARR_W-1:0] a);
        return NUM_ARR'(1) << a;
    endfunction

    function automatic logic row_fits(input logic [ROW_W-1:0] r);
        return (r >> LOC_W) == '0;
    endfunction
endpackage

// File: rtl/arr_bank_decode.sv
module arr_bank_decode
    import arr_addr_pkg::*;
(
    input  acc_kind_e          kind,
    input  gaddr_t             ga,
    input  logic [NUM_ARR-1:0] inst_mask,
    input  logic [NUM_ARR-1:0] data_mask,
    output bank_res_t          res
);
    logic [NUM_ARR-1:0] mask;
    logic               member;
    logic               fault;

    always_comb begin
        mask   = (kind == ACC_DATA) ? data_mask : inst_mask;
        member = mask[ga.arr];
        fault  = !member || !row_fits(ga.row);
        res.fault = fault;
        res.col   = ga.col;
        res.bank  = fault ? '0 : arr_onehot(ga.arr);
        res.row   = fault ? '0 : ga.row[LOC_W-1:0];
    end
endmodule

// File: rtl/arr_local_adder.sv
module arr_local_adder
    import arr_addr_pkg::*;
#(
    parameter int NUM_PE = 64
) (
    input  logic [LOC_W-1:0]        fixed_off,
    input  logic [LOC_W-1:0]        cu_index,
    input  logic [NUM_PE*LOC_W-1:0] pe_index,
    output logic [NUM_PE*LOC_W-1:0] pe_addr,
    output logic [NUM_PE-1:0]       pe_ovf
);
    logic [SUM_W-1:0] base;
    assign base = SUM_W'(fixed_off) + SUM_W'(cu_index);

    for (genvar g = 0; g < NUM_PE; g++) begin : g_pe
        logic [SUM_W-1:0] sum;
        assign sum = base + SUM_W'(pe_index[g*LOC_W +: LOC_W]);
        assign pe_addr[g*LOC_W +: LOC_W] = sum[LOC_W-1:0];
        assign pe_ovf[g] = |sum[SUM_W-1:LOC_W];
    end
endmodule

// File: rtl/arr_addr_gen.sv
module arr_addr_gen
    import arr_addr_pkg::*;
#(
    parameter int NUM_PE = 64
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    req_valid,
    input  logic                    req_is_data,
    input  logic [GA_W-1:0]         glob_addr,
    input  logic [NUM_ARR-1:0]      inst_mask,
    input  logic [NUM_ARR-1:0]      data_mask,
    input  logic [LOC_W-1:0]        fixed_off,
    input  logic [LOC_W-1:0]        cu_index,
    input  logic [NUM_PE*LOC_W-1:0] pe_index,
    output logic                    out_valid,
    output logic [NUM_ARR-1:0]      bank_sel,
    output logic [LOC_W-1:0]        row_addr,
    output logic [COL_W-1:0]        col_sel,
    output logic                    addr_fault,
    output logic [NUM_PE*LOC_W-1:0] pe_addr,
    output logic [NUM_PE-1:0]       pe_ovf
);
    bank_res_t                 dec;
    logic [NUM_PE*LOC_W-1:0]   sum_addr;
    logic [NUM_PE-1:0]         sum_ovf;
    acc_kind_e                 kind;

    assign kind = req_is_data ? ACC_DATA : ACC_INST;

    arr_bank_decode u_dec (
        .kind      (kind),
        .ga        (gaddr_t'(glob_addr)),
        .inst_mask (inst_mask),
        .data_mask (data_mask),
        .res       (dec)
    );

    arr_local_adder #(.NUM_PE(NUM_PE)) u_add (
        .fixed_off (fixed_off),
        .cu_index  (cu_index),
        .pe_index  (pe_index),
        .pe_addr   (sum_addr),
        .pe_ovf    (sum_ovf)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid  <= 1'b0;
            bank_sel   <= '0;
            row_addr   <= '0;
            col_sel    <= '0;
            addr_fault <= 1'b0;
            pe_addr    <= '0;
            pe_ovf     <= '0;
        end else begin
            out_valid <= req_valid;
            if (req_valid) begin
                bank_sel   <= dec.bank;
                row_addr   <= dec.row;
                col_sel    <= dec.col;
                addr_fault <= dec.fault;
                pe_addr    <= sum_addr;
                pe_ovf     <= sum_ovf;
            end
        end
    end
endmodule

// File: rtl/arr_addr_gen_chk.sv
module arr_addr_gen_chk
    import arr_addr_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               req_valid,
    input logic               req_is_data,
    input logic [GA_W-1:0]    glob_addr,
    input logic [NUM_ARR-1:0] inst_mask,
    input logic [NUM_ARR-1:0] data_mask,
    input logic               out_valid,
    input logic [NUM_ARR-1:0] bank_sel,
    input logic [LOC_W-1:0]   row_addr,
    input logic [COL_W-1:0]   col_sel,
    input logic               addr_fault
);
    logic armed;
    always_ff @(posedge clk) begin
        if (rst) armed <= 1'b0;
        else     armed <= 1'b1;
    end

    // R2
    valid_latency_chk: assert property (@(posedge clk) disable iff (rst)
        armed |-> (out_valid == $past(req_valid)));

    // R4
    bank_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(bank_sel));

    // R5
    fault_gate_chk: assert property (@(posedge clk) disable iff (rst)
        addr_fault |-> (bank_sel == '0 && row_addr == '0));

    // R3
    mask_obey_chk: assert property (@(posedge clk) disable iff (rst)
        (armed && $past(req_valid)) |->
        ((bank_sel & ~$past(req_is_data ? data_mask : inst_mask)) == '0));

    // R6
    col_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (armed && $past(req_valid)) |-> (col_sel == $past(glob_addr[COL_W-1:0])));

    // R9
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        (armed && !$past(req_valid)) |->
        ($stable(bank_sel) && $stable(row_addr) && $stable(addr_fault) && $stable(col_sel)));
endmodule

bind arr_addr_gen arr_addr_gen_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .req_valid   (req_valid),
    .req_is_data (req_is_data),
    .glob_addr   (glob_addr),
    .inst_mask   (inst_mask),
    .data_mask   (data_mask),
    .out_valid   (out_valid),
    .bank_sel    (bank_sel),
    .row_addr    (row_addr),
    .col_sel     (col_sel),
    .addr_fault  (addr_fault)
);

// File: tb/arr_addr_gen_bench.sv
`timescale 1ns/1ps
module arr_addr_gen_bench;
    localparam int NPE = 64;
    localparam int LW  = 11;

    logic              clk = 1'b0;
    logic              rst;
    logic              req_valid;
    logic              req_is_data;
    logic [19:0]       glob_addr;
    logic [3:0]        inst_mask;
    logic [3:0]        data_mask;
    logic [LW-1:0]     fixed_off;
    logic [LW-1:0]     cu_index;
    logic [NPE*LW-1:0] pe_index;
    logic              out_valid;
    logic [3:0]        bank_sel;
    logic [LW-1:0]     row_addr;
    logic [5:0]        col_sel;
    logic              addr_fault;
    logic [NPE*LW-1:0] pe_addr;
    logic [NPE-1:0]    pe_ovf;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    arr_addr_gen #(.NUM_PE(NPE)) u_arr_addr_gen (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_is_data(req_is_data),
        .glob_addr(glob_addr), .inst_mask(inst_mask), .data_mask(data_mask),
        .fixed_off(fixed_off), .cu_index(cu_index), .pe_index(pe_index),
        .out_valid(out_valid), .bank_sel(bank_sel), .row_addr(row_addr),
        .col_sel(col_sel), .addr_fault(addr_fault), .pe_addr(pe_addr), .pe_ovf(pe_ovf)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic exp_fault(input logic [19:0] a, input logic [3:0] m);
        return !m[a[7:6]] || a[19];
    endfunction

    function automatic logic [3:0] exp_bank(input logic [19:0] a, input logic [3:0] m);
        return exp_fault(a, m) ? 4'b0 : (4'b1 << a[7:6]);
    endfunction

    function automatic logic [10:0] exp_row(input logic [19:0] a, input logic [3:0] m);
        return exp_fault(a, m) ? 11'b0 : a[18:8];
    endfunction

    task automatic check_outputs(input logic [19:0] a, input logic [3:0] m);
        bit ok_pe = 1;
        int bad = -1;
        logic [12:0] s = 0;
        chk(out_valid == 1'b1, "R2 out_valid", 64'(out_valid), 64'(1));
        chk(addr_fault == exp_fault(a, m), "R5 fault", 64'(addr_fault), 64'(exp_fault(a, m)));
        chk(bank_sel == exp_bank(a, m), "R3/R4 bank_sel", 64'(bank_sel), 64'(exp_bank(a, m)));
        chk(row_addr == exp_row(a, m), "R6 row_addr", 64'(row_addr), 64'(exp_row(a, m)));
        chk(col_sel == a[5:0], "R6 col_sel", 64'(col_sel), 64'(a[5:0]));
        for (int i = 0; i < NPE; i++) begin
            s = 13'(fixed_off) + 13'(cu_index) + 13'(pe_index[i*LW +: LW]);
            if (pe_addr[i*LW +: LW] != s[10:0] || pe_ovf[i] != (s >= 13'd2048)) begin
                if (ok_pe) bad = i;
                ok_pe = 0;
            end
        end
        if (bad >= 0) begin
            s = 13'(fixed_off) + 13'(cu_index) + 13'(pe_index[bad*LW +: LW]);
            chk(0, "R7/R8 local pe", {52'(pe_ovf[bad]), pe_addr[bad*LW +: LW]},
                {52'(s >= 13'd2048), s[10:0]});
        end else begin
            chk(1, "R7/R8 local pe", 0, 0);
        end
    endtask

    task automatic issue(input logic [19:0] a, input logic d, input logic [3:0] im,
                         input logic [3:0] dm);
        @(negedge clk);
        req_valid = 1; req_is_data = d; glob_addr = a; inst_mask = im; data_mask = dm;
        @(negedge clk);
        req_valid = 0;
        check_outputs(a, d ? dm : im);
    endtask

    task automatic rand_pe();
        fixed_off = LW'($urandom);
        cu_index  = LW'($urandom);
        for (int i = 0; i < NPE; i++) pe_index[i*LW +: LW] = LW'($urandom);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [19:0] a;
        logic [3:0]  sb;
        logic [10:0] sr;
        logic        sf;
        process::self().srandom(32'h5eed);
        rst = 1; req_valid = 0; req_is_data = 0; glob_addr = 0;
        inst_mask = 0; data_mask = 0; fixed_off = 0; cu_index = 0; pe_index = '1;
        repeat (4) @(negedge clk);
        // R1 reset state during reset
        chk(!out_valid && bank_sel == 0 && row_addr == 0 && !addr_fault && pe_addr == 0 && pe_ovf == 0,
            "R1 reset", 64'(out_valid), 0);
        rst = 0;
        @(negedge clk);
        chk(!out_valid && bank_sel == 0 && col_sel == 0 && pe_addr == 0, "R1 post-reset", 64'(bank_sel), 0);

        // Directed corner cases
        rand_pe();
        issue({12'd5, 2'd2, 6'd9}, 1'b0, 4'b0000, 4'b1111);       // R5 empty inst mask
        issue({12'd5, 2'd2, 6'd9}, 1'b1, 4'b0000, 4'b0100);       // R3 data mask used
        issue({12'd2047, 2'd3, 6'd63}, 1'b0, 4'b1111, 4'b0000);   // R6 max row
        issue({12'd2048, 2'd0, 6'd1}, 1'b0, 4'b1111, 4'b1111);    // R5 row out of range
        fixed_off = 11'd2047; cu_index = 11'd1; pe_index = '0;
        issue({12'd1, 2'd1, 6'd0}, 1'b1, 4'b0000, 4'b0010);       // R8 sum exactly 2048
        fixed_off = 11'd2047; cu_index = 11'd0; pe_index = '0;
        issue({12'd1, 2'd1, 6'd0}, 1'b1, 4'b0000, 4'b0010);       // R8 sum 2047, no wrap
        fixed_off = '1; cu_index = '1; pe_index = '1;
        issue({12'd7, 2'd0, 6'd2}, 1'b0, 4'b0001, 4'b0000);       // R7 max sum wraps

        // R9 hold: idle cycle with changed inputs
        a = {12'd300, 2'd1, 6'd17};
        issue(a, 1'b0, 4'b0010, 4'b0000);
        sb = bank_sel; sr = row_addr; sf = addr_fault;
        @(negedge clk);
        req_valid = 0; glob_addr = {12'd9, 2'd3, 6'd4}; inst_mask = 4'b1000; rand_pe();
        @(negedge clk);
        chk(!out_valid, "R2 idle valid low", 64'(out_valid), 0);
        chk(bank_sel == sb && row_addr == sr && addr_fault == sf && col_sel == 6'd17,
            "R9 hold", {bank_sel, row_addr}, {sb, sr});

        // Constrained random
        for (int n = 0; n < 300; n++) begin
            a = 20'($urandom);
            if (($urandom % 8) != 0) a[19] = 1'b0;
            rand_pe();
            issue(a, 1'($urandom), 4'($urandom), 4'($urandom));
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule